// File: doc/BRIEF.md
# Coarse-Bin Keyed Hit Store

This block collects detector hits for one event into a hit-list memory arranged as a small database. A host-loadable lookup table maps each arriving hit, using its layer and a few low bits of the hit word, to a coarse bin and to the number of slots that bin may fill. A fast per-bin occupancy counter supplies each write address and is updated by a read-modify-write every input cycle. Hits that arrive after a bin is full are thrown away and reported.

Once the hit stream of an event has been closed by an end-of-event word, the block turns to the road stream. For every road it steps a layer counter from layer 0 up to the configured last layer. A second host-loadable table, indexed by layer and the low bits of the road word, names the bin to read for that layer. The block emits every hit stored in those bins, then the road word itself, which is flagged as the end of the packet. The road end-of-event word closes the event. Its tag is compared with the hit-side tag, and all bin counters are cleared for the next event.

The output is a registered word stream with a hold input from downstream, which can be set to be ignored. Both inputs have no back-pressure and enter through small queues. Sticky error flags report bad parity, queue overflow and invalid words on each input, and also lost synchronisation, bin overflow and exceeding the per-event road limit.

Top module: `binhit_store`

## Requirements
- R1: After reset, out_valid is 0 and all nine bits of err are 0.
- R2: A hit table entry is addressed by {hit_layer, hit_data[KEY_W-1:0]} and holds the bin in bits [BIN_W-1:0], the slot code in bits [BIN_W+1:BIN_W] and a valid bit in bit BIN_W+2. A road table entry is addressed by {layer, road_data[KEY_W-1:0]} and holds the bin in bits [BIN_W-1:0] and a valid bit in bit BIN_W. The tables are written through cfg_we, with cfg_tbl_sel set to 0 for the hit table and 1 for the road table.
- R3: Slot code 0 gives 2 slots, 1 gives 4, and 2 or 3 give 8. A hit arriving when its bin already holds that many hits is dropped and sets err[7].
- R4: For each accepted road the output packet holds, for layers 0 up to cfg_layers_m1 in ascending order, the hits of that layer's bin in arrival order with out_eop=0, followed by the road word with out_eop=1.
- R5: A road end-of-event word clears every bin, so hits from earlier events never appear in later packets.
- R6: cfg_layers_m1 sets the last layer of the readout loop. A hit whose layer is above cfg_layers_m1 is dropped and sets err[2].
- R7: Each input has a queue of FIFO_DEPTH words. A word that arrives while its queue is full is dropped and sets err[1] for hits or err[4] for roads.
- R8: The XOR of each input word with its parity bit must be 0. A word that fails this check is dropped and sets err[0] for hits or err[3] for roads.
- R9: A hit whose table entry is invalid is dropped and sets err[2]. A road layer whose table entry is invalid contributes no hits and sets err[5].
- R10: An end-of-event word carries its tag in data[TAG_W-1:0]. If the hit-side tag and the road-side tag differ, err[6] is set.
- R11: Roads beyond MAX_ROADS in one event are dropped with no packet and set err[8].
- R12: While out_valid is 1, out_hold is 1 and cfg_hold_ignore is 0, the output word holds steady. With cfg_hold_ignore set to 1, the stream flows whatever the state of out_hold.
- R13: Roads are processed only after the hit end-of-event word. Hits of the next event wait in their queue until the road end-of-event word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_tbl_sel | input | 1 | 0 selects the hit table, 1 selects the road table |
| cfg_addr | input | 3+KEY_W | Table entry address {layer, key} |
| cfg_wdata | input | BIN_W+3 | Table entry value |
| cfg_layers_m1 | input | 3 | Index of the last layer |
| cfg_hold_ignore | input | 1 | Ignore downstream hold |
| hit_valid | input | 1 | Hit word present |
| hit_eoe | input | 1 | Hit word is an end-of-event word |
| hit_layer | input | 3 | Layer of the hit |
| hit_data | input | HIT_W | Hit word, or the tag for an end-of-event word |
| hit_par | input | 1 | Parity bit for hit_data |
| road_valid | input | 1 | Road word present |
| road_eoe | input | 1 | Road word is an end-of-event word |
| road_data | input | HIT_W | Road word, or the tag for an end-of-event word |
| road_par | input | 1 | Parity bit for road_data |
| out_valid | output | 1 | Output word present |
| out_data | output | HIT_W | Output word |
| out_eop | output | 1 | Last word of the packet (the road) |
| out_hold | input | 1 | Downstream hold |
| err | output | 9 | Sticky error flags |

## Verification
The bench builds the block with FIFO_DEPTH=4 and MAX_ROADS=4, and runs it with two layers enabled. With these values five back-to-back words are enough to overflow a queue, and five roads are enough to pass the road limit. Bins of 2, 4 and 8 slots are loaded, so the bench can fill a bin to overflow and then read it back complete in a few dozen cycles.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int LAYER_W = 3;
  localparam int SLOT_W  = 3;
  localparam int CNT_W   = SLOT_W + 1;
  localparam int ERR_W   = 9;

  localparam int E_HIT_PAR  = 0;
  localparam int E_HIT_OVF  = 1;
  localparam int E_HIT_INV  = 2;
  localparam int E_ROAD_PAR = 3;
  localparam int E_ROAD_OVF = 4;
  localparam int E_ROAD_INV = 5;
  localparam int E_SYNC     = 6;
  localparam int E_BIN_OVF  = 7;
  localparam int E_INT_OVF  = 8;

  typedef enum logic [2:0] {
    R_IDLE, R_LUT, R_BIN, R_ADDR, R_DATA, R_ROAD
  } rd_state_e;

  typedef enum logic { PH_FILL, PH_READ } phase_e;

  function automatic logic [CNT_W-1:0] slot_limit(input logic [1:0] code);
    case (code)
      2'd0:    return CNT_W'(2);
      2'd1:    return CNT_W'(4);
      default: return CNT_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/hs_fifo.sv
module hs_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] fill;
  logic          do_push, do_pop;

  assign empty   = (fill == '0);
  assign full    = (fill == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = store[rp];

  always_ff @(posedge clk) begin
    if (do_push) store[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  // A full queue that is not drained stays full: extra pushes are refused.
  assert_queue_refuses_when_full_R7: assert property (
    @(posedge clk) disable iff (rst) (full && !pop) |=> full);
endmodule

// File: rtl/hs_sdp_ram.sv
module hs_sdp_ram #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [2**AW];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/binhit_store.sv
module binhit_store
  import hs_pkg::*;
#(
  parameter int HIT_W      = 21,
  parameter int KEY_W      = 4,
  parameter int BIN_W      = 5,
  parameter int FIFO_DEPTH = 8,
  parameter int TAG_W      = 8,
  parameter int MAX_ROADS  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic                     cfg_tbl_sel,
  input  logic [LAYER_W+KEY_W-1:0] cfg_addr,
  input  logic [BIN_W+2:0]         cfg_wdata,
  input  logic [LAYER_W-1:0]       cfg_layers_m1,
  input  logic                     cfg_hold_ignore,
  input  logic                     hit_valid,
  input  logic                     hit_eoe,
  input  logic [LAYER_W-1:0]       hit_layer,
  input  logic [HIT_W-1:0]         hit_data,
  input  logic                     hit_par,
  input  logic                     road_valid,
  input  logic                     road_eoe,
  input  logic [HIT_W-1:0]         road_data,
  input  logic                     road_par,
  output logic                     out_valid,
  output logic [HIT_W-1:0]         out_data,
  output logic                     out_eop,
  input  logic                     out_hold,
  output logic [ERR_W-1:0]         err
);
  localparam int TBL_AW = LAYER_W + KEY_W;
  localparam int HENT_W = BIN_W + 3;
  localparam int RENT_W = BIN_W + 1;
  localparam int NBINS  = 2 ** BIN_W;
  localparam int MEM_AW = BIN_W + SLOT_W;
  localparam int HQ_W   = HIT_W + LAYER_W + 1;
  localparam int RQ_W   = HIT_W + 1;
  localparam int RC_W   = $clog2(MAX_ROADS + 1);

  // ---------------- input queues ----------------
  logic hit_par_ok, road_par_ok;
  logic hq_push, hq_pop, hq_empty, hq_full;
  logic rq_push, rq_pop, rq_empty, rq_full;
  logic [HQ_W-1:0] hq_dout;
  logic [RQ_W-1:0] rq_dout;
  logic                hq_eoe, rq_eoe;
  logic [LAYER_W-1:0]  hq_layer;
  logic [HIT_W-1:0]    hq_data, rq_data;

  assign hit_par_ok  = ~^{hit_data, hit_par};
  assign road_par_ok = ~^{road_data, road_par};
  assign hq_push     = hit_valid && hit_par_ok;
  assign rq_push     = road_valid && road_par_ok;

  hs_fifo #(.W(HQ_W), .DEPTH(FIFO_DEPTH)) u_hit_q (
    .clk(clk), .rst(rst), .push(hq_push), .din({hit_eoe, hit_layer, hit_data}),
    .pop(hq_pop), .dout(hq_dout), .empty(hq_empty), .full(hq_full));

  hs_fifo #(.W(RQ_W), .DEPTH(FIFO_DEPTH)) u_road_q (
    .clk(clk), .rst(rst), .push(rq_push), .din({road_eoe, road_data}),
    .pop(rq_pop), .dout(rq_dout), .empty(rq_empty), .full(rq_full));

  assign {hq_eoe, hq_layer, hq_data} = hq_dout;
  assign {rq_eoe, rq_data}           = rq_dout;

  // ---------------- lookup tables ----------------
  logic [HENT_W-1:0] hit_ent;
  logic [RENT_W-1:0] road_ent;
  logic [LAYER_W-1:0] layer_r;
  logic [HIT_W-1:0]   road_r;

  hs_sdp_ram #(.AW(TBL_AW), .DW(HENT_W)) u_hit_tbl (
    .clk(clk), .we(cfg_we && !cfg_tbl_sel), .waddr(cfg_addr), .wdata(cfg_wdata),
    .raddr({hq_layer, hq_data[KEY_W-1:0]}), .rdata(hit_ent));

  hs_sdp_ram #(.AW(TBL_AW), .DW(RENT_W)) u_road_tbl (
    .clk(clk), .we(cfg_we && cfg_tbl_sel), .waddr(cfg_addr),
    .wdata(cfg_wdata[RENT_W-1:0]),
    .raddr({layer_r, road_r[KEY_W-1:0]}), .rdata(road_ent));

  // ---------------- phase and fill stage ----------------
  phase_e phase;
  logic   fill_stop;
  logic   s1_valid, s1_eoe;
  logic [LAYER_W-1:0] s1_layer;
  logic [HIT_W-1:0]   s1_data;
  logic [TAG_W-1:0]   hit_tag;

  logic [CNT_W-1:0] bin_cnt [NBINS];

  logic             hent_valid;
  logic [1:0]       hent_code;
  logic [BIN_W-1:0] hent_bin;
  logic [CNT_W-1:0] hent_fill;
  logic             s1_hit, s1_bad, s1_wr, s1_full;

  assign hent_valid = hit_ent[BIN_W+2];
  assign hent_code  = hit_ent[BIN_W+1:BIN_W];
  assign hent_bin   = hit_ent[BIN_W-1:0];
  assign hent_fill  = bin_cnt[hent_bin];

  assign hq_pop  = (phase == PH_FILL) && !fill_stop && !hq_empty;
  assign s1_hit  = s1_valid && !s1_eoe;
  assign s1_bad  = s1_hit && ((s1_layer > cfg_layers_m1) || !hent_valid);
  assign s1_full = hent_fill >= slot_limit(hent_code);
  assign s1_wr   = s1_hit && !s1_bad && !s1_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_eoe    <= 1'b0;
      s1_layer  <= '0;
      s1_data   <= '0;
      fill_stop <= 1'b0;
      hit_tag   <= '0;
    end else begin
      s1_valid <= hq_pop;
      if (hq_pop) begin
        s1_eoe   <= hq_eoe;
        s1_layer <= hq_layer;
        s1_data  <= hq_data;
        if (hq_eoe) begin
          fill_stop <= 1'b1;
          hit_tag   <= hq_data[TAG_W-1:0];
        end
      end
      if (s1_valid && s1_eoe) fill_stop <= 1'b0;
    end
  end

  // ---------------- read-side state ----------------
  rd_state_e        st;
  logic [BIN_W-1:0] bin_r;
  logic [CNT_W-1:0] n_r, idx_r;
  logic [RC_W-1:0]  road_cnt;
  logic             rd_eoe_pop, rd_road_ok, clr_bins;
  logic             out_free, out_load;
  logic [HIT_W-1:0] out_next;
  logic             out_next_eop;
  logic [HIT_W-1:0] mem_rd;
  logic             last_layer;

  assign rq_pop     = (phase == PH_READ) && (st == R_IDLE) && !rq_empty;
  assign rd_eoe_pop = rq_pop && rq_eoe;
  assign rd_road_ok = rq_pop && !rq_eoe && (road_cnt != RC_W'(MAX_ROADS));
  assign clr_bins   = rd_eoe_pop;
  assign last_layer = (layer_r == cfg_layers_m1);
  assign out_free   = !out_valid || !out_hold || cfg_hold_ignore;

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_FILL;
    else if (s1_valid && s1_eoe) phase <= PH_READ;
    else if (rd_eoe_pop) phase <= PH_FILL;
  end

  // Per-bin occupancy: read, bump and write back in the same cycle.
  always_ff @(posedge clk) begin
    if (rst || clr_bins) begin
      for (int b = 0; b < NBINS; b++) bin_cnt[b] <= '0;
    end else if (s1_wr) begin
      bin_cnt[hent_bin] <= hent_fill + 1'b1;
    end
  end

  hs_sdp_ram #(.AW(MEM_AW), .DW(HIT_W)) u_hit_mem (
    .clk(clk), .we(s1_wr), .waddr({hent_bin, hent_fill[SLOT_W-1:0]}), .wdata(s1_data),
    .raddr({bin_r, idx_r[SLOT_W-1:0]}), .rdata(mem_rd));

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= R_IDLE;
      layer_r  <= '0;
      road_r   <= '0;
      bin_r    <= '0;
      n_r      <= '0;
      idx_r    <= '0;
      road_cnt <= '0;
    end else begin
      case (st)
        R_IDLE: begin
          if (rd_eoe_pop) road_cnt <= '0;
          if (rd_road_ok) begin
            road_r  <= rq_data;
            layer_r <= '0;
            st      <= R_LUT;
          end
        end
        R_LUT: st <= R_BIN;
        R_BIN: begin
          bin_r <= road_ent[BIN_W-1:0];
          n_r   <= bin_cnt[road_ent[BIN_W-1:0]];
          idx_r <= '0;
          if (road_ent[BIN_W] && (bin_cnt[road_ent[BIN_W-1:0]] != '0)) st <= R_ADDR;
          else if (last_layer) st <= R_ROAD;
          else begin
            layer_r <= layer_r + 1'b1;
            st      <= R_LUT;
          end
        end
        R_ADDR: st <= R_DATA;
        R_DATA: begin
          if (out_free) begin
            if (idx_r + 1'b1 == n_r) begin
              if (last_layer) st <= R_ROAD;
              else begin
                layer_r <= layer_r + 1'b1;
                st      <= R_LUT;
              end
            end else begin
              idx_r <= idx_r + 1'b1;
              st    <= R_ADDR;
            end
          end
        end
        R_ROAD: begin
          if (out_free) begin
            road_cnt <= road_cnt + 1'b1;
            st       <= R_IDLE;
          end
        end
        default: st <= R_IDLE;
      endcase
    end
  end

  // ---------------- output register ----------------
  always_comb begin
    out_load     = 1'b0;
    out_next     = mem_rd;
    out_next_eop = 1'b0;
    if (st == R_DATA && out_free) out_load = 1'b1;
    if (st == R_ROAD && out_free) begin
      out_load     = 1'b1;
      out_next     = road_r;
      out_next_eop = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_eop   <= 1'b0;
    end else if (out_load) begin
      out_valid <= 1'b1;
      out_data  <= out_next;
      out_eop   <= out_next_eop;
    end else if (out_free) begin
      out_valid <= 1'b0;
    end
  end

  // ---------------- sticky error flags ----------------
  logic [ERR_W-1:0] err_set;
  always_comb begin
    err_set             = '0;
    err_set[E_HIT_PAR]  = hit_valid && !hit_par_ok;
    err_set[E_HIT_OVF]  = hq_push && hq_full;
    err_set[E_HIT_INV]  = s1_bad;
    err_set[E_ROAD_PAR] = road_valid && !road_par_ok;
    err_set[E_ROAD_OVF] = rq_push && rq_full;
    err_set[E_ROAD_INV] = (st == R_BIN) && !road_ent[BIN_W];
    err_set[E_SYNC]     = rd_eoe_pop && (rq_data[TAG_W-1:0] != hit_tag);
    err_set[E_BIN_OVF]  = s1_hit && !s1_bad && s1_full;
    err_set[E_INT_OVF]  = rq_pop && !rq_eoe && !rd_road_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) err <= '0;
    else     err <= err | err_set;
  end

  // ---------------- checks ----------------
  logic any_bin_used;
  always_comb begin
    any_bin_used = 1'b0;
    for (int b = 0; b < NBINS; b++) any_bin_used = any_bin_used | (bin_cnt[b] != '0);
  end

  assert_out_steady_on_hold_R12: assert property (
    @(posedge clk) disable iff (rst)
    (out_valid && out_hold && !cfg_hold_ignore) |=>
      (out_valid && $stable(out_data) && $stable(out_eop)));

  assert_no_store_while_reading_R13: assert property (
    @(posedge clk) disable iff (rst) s1_wr |-> (phase == PH_FILL));

  assert_bins_empty_after_event_R5: assert property (
    @(posedge clk) disable iff (rst) rd_eoe_pop |=> !any_bin_used);

  assert_bin_fill_bound_R3: assert property (
    @(posedge clk) disable iff (rst)
    (st == R_BIN) |-> (bin_cnt[road_ent[BIN_W-1:0]] <= CNT_W'(8)));

  assert_layer_within_limit_R6: assert property (
    @(posedge clk) disable iff (rst) (st == R_LUT) |-> (layer_r <= cfg_layers_m1));
endmodule

// File: tb/binhit_store_tb.sv
module binhit_store_tb;
  localparam int HIT_W = 21;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 0, cfg_tbl_sel = 0, cfg_hold_ignore = 0;
  logic [6:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [2:0] cfg_layers_m1 = 3'd1;
  logic hit_valid = 0, hit_eoe = 0, hit_par = 0;
  logic [2:0] hit_layer = '0;
  logic [HIT_W-1:0] hit_data = '0;
  logic road_valid = 0, road_eoe = 0, road_par = 0;
  logic [HIT_W-1:0] road_data = '0;
  logic out_valid, out_eop;
  logic out_hold = 0;
  logic [HIT_W-1:0] out_data;
  logic [8:0] err;

  always #5 clk = ~clk;

  binhit_store #(.FIFO_DEPTH(4), .MAX_ROADS(4)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_tbl_sel(cfg_tbl_sel),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_layers_m1(cfg_layers_m1),
    .cfg_hold_ignore(cfg_hold_ignore), .hit_valid(hit_valid), .hit_eoe(hit_eoe),
    .hit_layer(hit_layer), .hit_data(hit_data), .hit_par(hit_par),
    .road_valid(road_valid), .road_eoe(road_eoe), .road_data(road_data),
    .road_par(road_par), .out_valid(out_valid), .out_data(out_data),
    .out_eop(out_eop), .out_hold(out_hold), .err(err));

  int checks = 0, fails = 0;
  logic [HIT_W-1:0] cap_d [256];
  logic             cap_e [256];
  int               cap_n = 0;
  logic [HIT_W-1:0] exp_d [64];
  logic             exp_e [64];
  int               exp_n = 0;
  logic [8:0]       exp_err = '0;

  // Output monitor: records each word in the cycle it leaves the block.
  always begin
    @(negedge clk);
    #2;
    if (out_valid && (!out_hold || cfg_hold_ignore)) begin
      cap_d[cap_n] = out_data;
      cap_e[cap_n] = out_eop;
      cap_n++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_tbl_sel = sel; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send_hit(input logic [2:0] l, input logic [HIT_W-1:0] d,
                          input logic eoe, input logic bad);
    hit_valid = 1; hit_eoe = eoe; hit_layer = l; hit_data = d;
    hit_par = bad ? ~(^d) : ^d;
    @(negedge clk);
    hit_valid = 0;
  endtask

  task automatic send_road(input logic [HIT_W-1:0] d, input logic eoe, input logic bad);
    road_valid = 1; road_eoe = eoe; road_data = d;
    road_par = bad ? ~(^d) : ^d;
    @(negedge clk);
    road_valid = 0;
  endtask

  task automatic start_case();
    @(negedge clk);
    cap_n = 0;
    exp_n = 0;
  endtask

  task automatic expect_word(input logic [HIT_W-1:0] d, input logic e);
    exp_d[exp_n] = d;
    exp_e[exp_n] = e;
    exp_n++;
  endtask

  task automatic check_packet(input string req);
    check({req, " word count"}, cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      check({req, " word"}, cap_d[i], exp_d[i]);
      check({req, " eop"}, cap_e[i], exp_e[i]);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R1
  task automatic t_reset();
    check("R1 out_valid", out_valid, 0);
    check("R1 err", err, 0);
  endtask

  // R2 R3 R4 R6: basic event, 2-slot bin overflows
  task automatic t_basic();
    start_case();
    send_hit(0, 21'h100001, 0, 0);
    send_hit(0, 21'h100011, 0, 0);
    send_hit(1, 21'h000021, 0, 0);
    send_hit(0, 21'h000031, 0, 0);
    send_hit(0, 21'd5, 1, 0);
    idle(5);
    send_road(21'h0AAA1, 0, 0);
    send_road(21'd5, 1, 0);
    idle(60);
    expect_word(21'h100001, 0);
    expect_word(21'h100011, 0);
    expect_word(21'h000021, 0);
    expect_word(21'h0AAA1, 1);
    check_packet("R4");
    exp_err[7] = 1;
    check("R3 bin overflow flag", err, exp_err);
  endtask

  // R5: bins start empty in a new event
  task automatic t_clear();
    start_case();
    send_hit(0, 21'h000051, 0, 0);
    send_hit(0, 21'd6, 1, 0);
    idle(5);
    send_road(21'h00AB1, 0, 0);
    send_road(21'd6, 1, 0);
    idle(60);
    expect_word(21'h000051, 0);
    expect_word(21'h00AB1, 1);
    check_packet("R5");
  endtask

  // R3 R6 R9: 4-slot bin, layer beyond limit, invalid road layer
  task automatic t_slots();
    start_case();
    for (int i = 1; i <= 5; i++) send_hit(0, 21'(i * 256 + 2), 0, 0);
    send_hit(3, 21'h000001, 0, 0);
    send_hit(0, 21'd8, 1, 0);
    idle(5);
    send_road(21'h00C02, 0, 0);
    send_road(21'd8, 1, 0);
    idle(60);
    for (int i = 1; i <= 4; i++) expect_word(21'(i * 256 + 2), 0);
    expect_word(21'h00C02, 1);
    check_packet("R3");
    exp_err[2] = 1; exp_err[5] = 1;
    check("R6 R9 invalid flags", err, exp_err);
  endtask

  // R12: hold stalls the stream; ignore lets it flow
  task automatic t_hold();
    logic [HIT_W-1:0] held;
    start_case();
    out_hold = 1;
    send_hit(1, 21'h0000A1, 0, 0);
    send_hit(0, 21'd7, 1, 0);
    idle(5);
    send_road(21'h00B01, 0, 0);
    send_road(21'd7, 1, 0);
    idle(40);
    check("R12 held valid", out_valid, 1);
    check("R12 nothing consumed", cap_n, 0);
    held = out_data;
    idle(6);
    check("R12 held word stable", out_data, held);
    check("R12 held word value", held, 21'h0000A1);
    out_hold = 0;
    idle(40);
    expect_word(21'h0000A1, 0);
    expect_word(21'h00B01, 1);
    check_packet("R12");
    start_case();
    out_hold = 1; cfg_hold_ignore = 1;
    send_hit(0, 21'h0000C1, 0, 0);
    send_hit(0, 21'd13, 1, 0);
    idle(5);
    send_road(21'h00CC1, 0, 0);
    send_road(21'd13, 1, 0);
    idle(60);
    expect_word(21'h0000C1, 0);
    expect_word(21'h00CC1, 1);
    check_packet("R12 ignore");
    out_hold = 0; cfg_hold_ignore = 0;
  endtask

  // R8
  task automatic t_parity();
    start_case();
    send_hit(0, 21'h000061, 0, 1);
    send_hit(0, 21'h000071, 0, 0);
    send_hit(0, 21'd20, 1, 0);
    idle(5);
    send_road(21'h00D01, 0, 1);
    send_road(21'h00E01, 0, 0);
    send_road(21'd20, 1, 0);
    idle(60);
    expect_word(21'h000071, 0);
    expect_word(21'h00E01, 1);
    check_packet("R8");
    exp_err[0] = 1; exp_err[3] = 1;
    check("R8 parity flags", err, exp_err);
  endtask

  // R10
  task automatic t_sync();
    start_case();
    send_hit(0, 21'd9, 1, 0);
    idle(5);
    send_road(21'd10, 1, 0);
    idle(20);
    check("R10 no output", cap_n, 0);
    exp_err[6] = 1;
    check("R10 lost sync flag", err, exp_err);
  endtask

  // R11
  task automatic t_roads();
    start_case();
    send_hit(0, 21'd21, 1, 0);
    idle(5);
    for (int i = 1; i <= 5; i++) begin
      send_road(21'(32'h00F00 + i * 16 + 1), 0, 0);
      idle(40);
    end
    send_road(21'd21, 1, 0);
    idle(20);
    for (int i = 1; i <= 4; i++) expect_word(21'(32'h00F00 + i * 16 + 1), 1);
    check_packet("R11");
    exp_err[8] = 1;
    check("R11 road limit flag", err, exp_err);
  endtask

  // R7 R13: hits of the next event queue up during readout
  task automatic t_hit_queue();
    start_case();
    send_hit(0, 21'd11, 1, 0);
    idle(5);
    for (int i = 1; i <= 5; i++) send_hit(1, 21'(i * 256 + 32'h11), 0, 0);
    idle(10);
    check("R13 no output before road", cap_n, 0);
    send_road(21'd11, 1, 0);
    idle(20);
    send_hit(0, 21'd12, 1, 0);
    idle(5);
    send_road(21'h01001, 0, 0);
    send_road(21'd12, 1, 0);
    idle(60);
    for (int i = 1; i <= 4; i++) expect_word(21'(i * 256 + 32'h11), 0);
    expect_word(21'h01001, 1);
    check_packet("R13");
    exp_err[1] = 1;
    check("R7 hit queue overflow flag", err, exp_err);
  endtask

  // R7 R13: roads queue while hits are still open
  task automatic t_road_queue();
    start_case();
    for (int i = 1; i <= 5; i++) send_road(21'(32'h02000 + i * 16 + 1), 0, 0);
    idle(10);
    check("R13 roads wait for hit end", cap_n, 0);
    send_hit(0, 21'd30, 1, 0);
    idle(5);
    send_road(21'd30, 1, 0);
    idle(100);
    for (int i = 1; i <= 4; i++) expect_word(21'(32'h02000 + i * 16 + 1), 1);
    check_packet("R7");
    exp_err[4] = 1;
    check("R7 road queue overflow flag", err, exp_err);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    for (int a = 0; a < 128; a++) begin
      cfg_write(0, 7'(a), 8'h00);
      cfg_write(1, 7'(a), 8'h00);
    end
    cfg_write(0, 7'h01, 8'h83);   // L0 key1 -> bin3, 2 slots
    cfg_write(0, 7'h02, 8'hA4);   // L0 key2 -> bin4, 4 slots
    cfg_write(0, 7'h11, 8'hC5);   // L1 key1 -> bin5, 8 slots
    cfg_write(1, 7'h01, 8'h23);   // road L0 key1 -> bin3
    cfg_write(1, 7'h11, 8'h25);   // road L1 key1 -> bin5
    cfg_write(1, 7'h02, 8'h24);   // road L0 key2 -> bin4
    t_basic();
    t_clear();
    t_slots();
    t_hold();
    t_parity();
    t_sync();
    t_roads();
    t_hit_queue();
    t_road_queue();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule